// File: doc/BRIEF.md
# Sector Buffer DMA Transfer Engine

This engine copies a run of bytes from a 16 KB circular sector buffer into one of five destination memories: a 4 KB sample RAM window, the large program RAM, the lower or upper half of a banked work RAM, or the whole work RAM. A start strobe loads the source pointer, the destination address register, the data byte counter, a channel select and the host status byte. The engine then issues one byte write per clock. The write goes to the strobe of the selected memory, and its data is read that same cycle from the buffer's combinational read port.

Each destination turns the address register into a byte address in its own way: a shift, then a mask to that memory's size. The copy is clipped so that it never runs past the end of the memory. The source pointer wraps inside the ring.

When the copy ends, the engine writes the pointers back in units that depend on the destination, reloads the byte counter, returns its active-low status flags to idle and rewrites the host status byte. It pulses a done strobe and, when both enables allow it, a level-5 interrupt request.

Top module: `cdbuf_dma`

## Requirements
- R1: After reset: `dtbsy_n_o`, `dten_n_o` and `dtei_n_o` are 1. `done_o`, `irq5_o`, `we_o`, `chan_o`, `src_o`, `dadr_o` and `hstat_o` are 0, and `dbc_o` is 16'hF000.
- R2: Channel codes are 1 sample RAM, 2 program RAM, 3 work RAM lower half, 4 work RAM upper half, 5 full work RAM. A start with code c (1..5) writes exactly one byte per clock, starting the cycle after the start edge. Each write raises only `we_o[c-1]`, and `wr_data_o` equals the buffer byte at `rd_addr_o`.
- R3: Reading starts at `src_i` with bit 0 cleared and advances by one per byte. After 14'h3FFF it wraps to 14'h0000.
- R4: Sample RAM: the first write address is (dadr<<2) & 12'hFFC. The length is dbc+1 bytes, odd lengths included, cut short so that the last byte lands at 0xFFF at most.
- R5: Program RAM: the first write address is dadr<<3. The length is (dbc+1) with bit 0 cleared, cut short at the limit 0x80000.
- R6: Work RAM half: the first address is (dadr<<3) & 0x1FFFE, with limit 0x20000. Full work RAM: the mask is 0x3FFFE and the limit is 0x40000. Both use the even length of R5. An even length of zero produces no write.
- R7: With n = dbc+1, `src_o` becomes src_i + n on channel 1 and src_i + (n with bit 0 cleared) on the others, modulo 2^14. `dadr_o` becomes dadr + (n>>2) on channel 1 and dadr + (n>>3) on the others, modulo 2^16. The clipping of R4 to R6 does not change these values.
- R8: During a transfer `dbc_o` shows the loaded 12-bit count, zero-extended. At completion it becomes 16'hF000.
- R9: During a transfer `dtbsy_n_o` and `dten_n_o` are 0 and `hstat_o` equals the loaded `hstat_i`. At completion both flags become 1 and `hstat_o` becomes (hstat_i & 8'h07) | 8'h80.
- R10: A start arms `dtei_n_o` to 0. At completion the engine sets it back to 1 and raises `irq5_o` for one cycle, in the cycle where `done_o` is high, only if `dteien_i` and `ien5_i` are both 1.
- R11: `done_o` is high for exactly one cycle, the cycle after the last write (or the second cycle after the start edge when the length is zero). In that cycle `chan_o` already reads 0.
- R12: A start strobe is ignored while a transfer runs, and also when the channel code is 0, 6 or 7. An ignored start changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| chan_i | input | 3 | Destination channel code |
| src_i | input | 14 | Source pointer into the ring |
| dadr_i | input | 16 | Destination address register |
| dbc_i | input | 12 | Data byte counter (length minus one) |
| hstat_i | input | 8 | Host status byte loaded at start |
| dteien_i | input | 1 | End-of-transfer interrupt enable |
| ien5_i | input | 1 | Level-5 interrupt mask bit |
| rd_addr_o | output | 14 | Buffer read address |
| rd_data_i | input | 8 | Buffer read data (same cycle) |
| we_o | output | 5 | One write strobe per destination |
| wr_addr_o | output | 19 | Destination byte address |
| wr_data_o | output | 8 | Destination write data |
| src_o | output | 14 | Source pointer register |
| dadr_o | output | 16 | Destination address register |
| dbc_o | output | 16 | Byte counter register |
| chan_o | output | 3 | Active channel, 0 when idle |
| hstat_o | output | 8 | Host status byte |
| dtbsy_n_o | output | 1 | Busy flag, active low |
| dten_n_o | output | 1 | Transfer enable flag, active low |
| dtei_n_o | output | 1 | End-of-transfer pending flag, active low |
| done_o | output | 1 | Completion pulse |
| irq5_o | output | 1 | Level-5 interrupt request pulse |

## Verification
The assertions take for granted that the buffer answers `rd_addr_o` with valid data in the same cycle, and that reset is applied from time zero, so the first-edge history is defined. They also assume `dteien_i` and `ien5_i` do not change between a start and its completion, since the engine samples them only at the closing edge. The bench models the buffer as a pure function of the read address and drives it continuously. It changes inputs only on falling edges and holds the enables for the whole length of each transfer.

// File: rtl/cdd_pkg.sv
package cdd_pkg;

   typedef enum logic [2:0] {
      CH_NONE  = 3'd0,
      CH_PCM   = 3'd1,
      CH_PRG   = 3'd2,
      CH_WRH0  = 3'd3,
      CH_WRH1  = 3'd4,
      CH_WRALL = 3'd5
   } chan_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } xfer_st_e;

   localparam int unsigned N_DEST = 5;

   function automatic logic chan_ok(input logic [2:0] c);
      return (c != 3'd0) && (c <= 3'(N_DEST));
   endfunction

endpackage

// File: rtl/cdd_geom.sv
module cdd_geom #(
   parameter int DA_W      = 16,
   parameter int CNT_W     = 12,
   parameter int MEM_AW    = 19,
   parameter int PCM_AW    = 12,
   parameter int WRH_AW    = 17,
   parameter int WRF_AW    = 18,
   parameter int PCM_SHIFT = 2,
   parameter int RAM_SHIFT = 3,
   localparam int LEN_W    = CNT_W + 1
) (
   input  logic [2:0]        chan_i,
   input  logic [DA_W-1:0]   dadr_i,
   input  logic [CNT_W-1:0]  dbc_i,
   output logic [MEM_AW-1:0] base_o,
   output logic [LEN_W-1:0]  len_o
);
   import cdd_pkg::*;

   localparam int XW = MEM_AW + 1;
   localparam int AW_TAB [N_DEST] = '{PCM_AW, MEM_AW, WRH_AW, WRH_AW, WRF_AW};
   localparam int SH_TAB [N_DEST] = '{PCM_SHIFT, RAM_SHIFT, RAM_SHIFT, RAM_SHIFT, RAM_SHIFT};
   localparam bit ODD_TAB [N_DEST] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

   logic [XW-1:0]     dadr_x;
   logic [XW-1:0]     bytes_x;
   logic [XW-1:0]     even_x;
   logic [MEM_AW-1:0] base_a [N_DEST];
   logic [LEN_W-1:0]  len_a  [N_DEST];

   assign dadr_x  = XW'(dadr_i);
   assign bytes_x = XW'(dbc_i) + XW'(1);
   assign even_x  = {bytes_x[XW-1:1], 1'b0};

   for (genvar d = 0; d < N_DEST; d++) begin : g_dest
      localparam logic [XW-1:0] LIM = XW'(1) << AW_TAB[d];
      logic [XW-1:0] base_w;
      logic [XW-1:0] room_w;
      logic [XW-1:0] want_w;
      assign base_w   = (dadr_x << SH_TAB[d]) & (LIM - XW'(1));
      assign room_w   = LIM - base_w;
      assign want_w   = ODD_TAB[d] ? bytes_x : even_x;
      assign base_a[d] = base_w[MEM_AW-1:0];
      assign len_a[d]  = (want_w > room_w) ? LEN_W'(room_w) : LEN_W'(want_w);
   end

   always_comb begin
      base_o = '0;
      len_o  = '0;
      for (int d = 0; d < N_DEST; d++) begin
         if (chan_i == 3'(d + 1)) begin
            base_o = base_a[d];
            len_o  = len_a[d];
         end
      end
   end

endmodule

// File: rtl/cdd_seq.sv
module cdd_seq #(
   parameter int SRC_AW = 14,
   parameter int MEM_AW = 19,
   parameter int LEN_W  = 13,
   parameter int N_WE   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok_i,
   input  logic [2:0]        chan_i,
   input  logic [SRC_AW-1:0] src_i,
   input  logic [MEM_AW-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              busy_o,
   output logic              fin_o,
   output logic [N_WE-1:0]   we_o,
   output logic [MEM_AW-1:0] wr_addr_o,
   output logic [SRC_AW-1:0] rd_addr_o
);
   import cdd_pkg::*;

   xfer_st_e          st_q;
   logic [LEN_W-1:0]  rem_q;
   logic [SRC_AW-1:0] rp_q;
   logic [MEM_AW-1:0] wp_q;
   logic [2:0]        ch_q;
   logic              moving;

   assign moving    = (st_q == ST_XFER) && (rem_q != '0);
   assign fin_o     = (st_q == ST_XFER) && (rem_q <= LEN_W'(1));
   assign busy_o    = (st_q == ST_XFER);
   assign wr_addr_o = wp_q;
   assign rd_addr_o = rp_q;

   for (genvar d = 0; d < N_WE; d++) begin : g_we
      assign we_o[d] = moving && (ch_q == 3'(d + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         rem_q <= '0;
         rp_q  <= '0;
         wp_q  <= '0;
         ch_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_ok_i) begin
                  st_q  <= ST_XFER;
                  rem_q <= len_i;
                  rp_q  <= {src_i[SRC_AW-1:1], 1'b0};
                  wp_q  <= base_i;
                  ch_q  <= chan_i;
               end
            end
            default: begin
               if (moving) begin
                  rem_q <= rem_q - 1'b1;
                  rp_q  <= rp_q + 1'b1;
                  wp_q  <= wp_q + 1'b1;
               end
               if (fin_o) begin
                  st_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/cdd_stat.sv
module cdd_stat #(
   parameter int SRC_AW    = 14,
   parameter int DA_W      = 16,
   parameter int CNT_W     = 12,
   parameter int PCM_SHIFT = 2,
   parameter int RAM_SHIFT = 3,
   localparam int LEN_W    = CNT_W + 1,
   localparam int DBC_W    = CNT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok_i,
   input  logic              fin_i,
   input  logic [2:0]        chan_i,
   input  logic [SRC_AW-1:0] src_i,
   input  logic [DA_W-1:0]   dadr_i,
   input  logic [CNT_W-1:0]  dbc_i,
   input  logic [7:0]        hstat_i,
   input  logic              dteien_i,
   input  logic              ien5_i,
   output logic [SRC_AW-1:0] src_o,
   output logic [DA_W-1:0]   dadr_o,
   output logic [DBC_W-1:0]  dbc_o,
   output logic [2:0]        chan_o,
   output logic [7:0]        hstat_o,
   output logic              dtbsy_n_o,
   output logic              dten_n_o,
   output logic              dtei_n_o,
   output logic              done_o,
   output logic              irq5_o
);
   import cdd_pkg::*;

   localparam logic [DBC_W-1:0] DBC_IDLE = {4'hF, {CNT_W{1'b0}}};

   logic [LEN_W-1:0]  bytes_q;
   logic              is_pcm;
   logic [SRC_AW-1:0] src_adv;
   logic [DA_W-1:0]   dadr_adv;

   assign is_pcm   = (chan_o == CH_PCM);
   assign src_adv  = is_pcm ? SRC_AW'(bytes_q) : SRC_AW'({bytes_q[LEN_W-1:1], 1'b0});
   assign dadr_adv = is_pcm ? DA_W'(bytes_q >> PCM_SHIFT) : DA_W'(bytes_q >> RAM_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bytes_q   <= '0;
         src_o     <= '0;
         dadr_o    <= '0;
         dbc_o     <= DBC_IDLE;
         chan_o    <= '0;
         hstat_o   <= '0;
         dtbsy_n_o <= 1'b1;
         dten_n_o  <= 1'b1;
         dtei_n_o  <= 1'b1;
         done_o    <= 1'b0;
         irq5_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         irq5_o <= 1'b0;
         if (start_ok_i) begin
            bytes_q   <= LEN_W'(dbc_i) + LEN_W'(1);
            src_o     <= src_i;
            dadr_o    <= dadr_i;
            dbc_o     <= DBC_W'(dbc_i);
            chan_o    <= chan_i;
            hstat_o   <= hstat_i;
            dtbsy_n_o <= 1'b0;
            dten_n_o  <= 1'b0;
            dtei_n_o  <= 1'b0;
         end else if (fin_i) begin
            src_o     <= src_o + src_adv;
            dadr_o    <= dadr_o + dadr_adv;
            dbc_o     <= DBC_IDLE;
            chan_o    <= CH_NONE;
            hstat_o   <= {2'b10, 3'b000, hstat_o[2:0]};
            dtbsy_n_o <= 1'b1;
            dten_n_o  <= 1'b1;
            done_o    <= 1'b1;
            if (!dtei_n_o) begin
               dtei_n_o <= 1'b1;
               irq5_o   <= dteien_i && ien5_i;
            end
         end
      end
   end

endmodule

// File: rtl/cdbuf_dma.sv
module cdbuf_dma #(
   parameter int SRC_AW    = 14,
   parameter int DA_W      = 16,
   parameter int CNT_W     = 12,
   parameter int MEM_AW    = 19,
   parameter int PCM_AW    = 12,
   parameter int WRH_AW    = 17,
   parameter int WRF_AW    = 18,
   parameter int PCM_SHIFT = 2,
   parameter int RAM_SHIFT = 3,
   localparam int N_WE     = 5,
   localparam int DBC_W    = CNT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        chan_i,
   input  logic [SRC_AW-1:0] src_i,
   input  logic [DA_W-1:0]   dadr_i,
   input  logic [CNT_W-1:0]  dbc_i,
   input  logic [7:0]        hstat_i,
   input  logic              dteien_i,
   input  logic              ien5_i,
   output logic [SRC_AW-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic [N_WE-1:0]   we_o,
   output logic [MEM_AW-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic [SRC_AW-1:0] src_o,
   output logic [DA_W-1:0]   dadr_o,
   output logic [DBC_W-1:0]  dbc_o,
   output logic [2:0]        chan_o,
   output logic [7:0]        hstat_o,
   output logic              dtbsy_n_o,
   output logic              dten_n_o,
   output logic              dtei_n_o,
   output logic              done_o,
   output logic              irq5_o
);
   import cdd_pkg::*;

   localparam int LEN_W = CNT_W + 1;

   if (N_WE != N_DEST) begin : g_bad_dest
      $error("write strobe count must match destination count");
   end
   if (MEM_AW < DA_W + RAM_SHIFT) begin : g_bad_mem
      $error("program RAM address too narrow for shifted register");
   end
   if ((WRF_AW > MEM_AW) || (WRH_AW > WRF_AW) || (PCM_AW > WRH_AW)) begin : g_bad_order
      $error("destination windows must nest inside the write address");
   end
   if (LEN_W > SRC_AW) begin : g_bad_len
      $error("transfer length must not exceed the ring size");
   end

   logic              busy;
   logic              fin;
   logic              start_ok;
   logic [MEM_AW-1:0] base;
   logic [LEN_W-1:0]  len;

   assign start_ok  = start_i && !busy && chan_ok(chan_i);
   assign wr_data_o = rd_data_i;

   cdd_geom #(
      .DA_W(DA_W), .CNT_W(CNT_W), .MEM_AW(MEM_AW), .PCM_AW(PCM_AW),
      .WRH_AW(WRH_AW), .WRF_AW(WRF_AW), .PCM_SHIFT(PCM_SHIFT), .RAM_SHIFT(RAM_SHIFT)
   ) u_geom (
      .chan_i (chan_i),
      .dadr_i (dadr_i),
      .dbc_i  (dbc_i),
      .base_o (base),
      .len_o  (len)
   );

   cdd_seq #(
      .SRC_AW(SRC_AW), .MEM_AW(MEM_AW), .LEN_W(LEN_W), .N_WE(N_WE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok_i (start_ok),
      .chan_i     (chan_i),
      .src_i      (src_i),
      .base_i     (base),
      .len_i      (len),
      .busy_o     (busy),
      .fin_o      (fin),
      .we_o       (we_o),
      .wr_addr_o  (wr_addr_o),
      .rd_addr_o  (rd_addr_o)
   );

   cdd_stat #(
      .SRC_AW(SRC_AW), .DA_W(DA_W), .CNT_W(CNT_W),
      .PCM_SHIFT(PCM_SHIFT), .RAM_SHIFT(RAM_SHIFT)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok_i (start_ok),
      .fin_i      (fin),
      .chan_i     (chan_i),
      .src_i      (src_i),
      .dadr_i     (dadr_i),
      .dbc_i      (dbc_i),
      .hstat_i    (hstat_i),
      .dteien_i   (dteien_i),
      .ien5_i     (ien5_i),
      .src_o      (src_o),
      .dadr_o     (dadr_o),
      .dbc_o      (dbc_o),
      .chan_o     (chan_o),
      .hstat_o    (hstat_o),
      .dtbsy_n_o  (dtbsy_n_o),
      .dten_n_o   (dten_n_o),
      .dtei_n_o   (dtei_n_o),
      .done_o     (done_o),
      .irq5_o     (irq5_o)
   );

endmodule

// File: rtl/cdd_chk.sv
module cdd_chk #(
   parameter int CNT_W = 12,
   parameter int N_WE  = 5,
   localparam int DBC_W = CNT_W + 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_WE-1:0]  we_o,
   input logic [DBC_W-1:0] dbc_o,
   input logic [2:0]       chan_o,
   input logic [7:0]       hstat_o,
   input logic             dtbsy_n_o,
   input logic             dten_n_o,
   input logic             dtei_n_o,
   input logic             done_o,
   input logic             irq5_o
);

   // R2
   we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we_o));

   // R9
   we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_o != '0) |-> (!dtbsy_n_o && !dten_n_o));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   done_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (chan_o == 3'd0));

   // R8
   done_dbc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (dbc_o == {4'hF, {CNT_W{1'b0}}}));

   // R9
   done_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (dtbsy_n_o && dten_n_o && hstat_o[7] && !hstat_o[6]));

   // R10
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq5_o |-> (done_o && dtei_n_o));

   // R12
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtbsy_n_o && !$past(dtbsy_n_o)) |-> $stable(chan_o));

endmodule

bind cdbuf_dma cdd_chk #(.CNT_W(CNT_W), .N_WE(N_WE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .we_o      (we_o),
   .dbc_o     (dbc_o),
   .chan_o    (chan_o),
   .hstat_o   (hstat_o),
   .dtbsy_n_o (dtbsy_n_o),
   .dten_n_o  (dten_n_o),
   .dtei_n_o  (dtei_n_o),
   .done_o    (done_o),
   .irq5_o    (irq5_o)
);

// File: tb/cdbuf_dma_tb.sv
`timescale 1ns/1ps
module cdbuf_dma_tb;

   typedef struct packed {
      logic [2:0]  ch;
      logic [13:0] src;
      logic [15:0] dadr;
      logic [11:0] dbc;
      logic [7:0]  hs;
      logic        ten;
      logic        ien;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 14'h0100, 16'h0010, 12'd15,   8'h3F, 1'b1, 1'b1},
      '{3'd1, 14'h0203, 16'h03FE, 12'd31,   8'hC5, 1'b1, 1'b0},
      '{3'd1, 14'h1000, 16'h0400, 12'd4,    8'h00, 1'b0, 1'b1},
      '{3'd2, 14'h3FFB, 16'h1234, 12'd9,    8'hFF, 1'b1, 1'b1},
      '{3'd2, 14'h0040, 16'hFFFF, 12'd19,   8'h47, 1'b1, 1'b1},
      '{3'd3, 14'h2000, 16'h4003, 12'd6,    8'h12, 1'b0, 1'b0},
      '{3'd4, 14'h3FF0, 16'h3FFF, 12'd11,   8'h81, 1'b1, 1'b1},
      '{3'd5, 14'h0007, 16'hC000, 12'd2,    8'h06, 1'b1, 1'b1},
      '{3'd3, 14'h0011, 16'h0020, 12'd0,    8'hAA, 1'b1, 1'b1},
      '{3'd1, 14'h3F00, 16'h0000, 12'hFFF,  8'h01, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  chan_i = '0;
   logic [13:0] src_i = '0;
   logic [15:0] dadr_i = '0;
   logic [11:0] dbc_i = '0;
   logic [7:0]  hstat_i = '0;
   logic        dteien_i = 1'b0;
   logic        ien5_i = 1'b0;
   logic [13:0] rd_addr_o;
   logic [7:0]  rd_data_i;
   logic [4:0]  we_o;
   logic [18:0] wr_addr_o;
   logic [7:0]  wr_data_o;
   logic [13:0] src_o;
   logic [15:0] dadr_o;
   logic [15:0] dbc_o;
   logic [2:0]  chan_o;
   logic [7:0]  hstat_o;
   logic        dtbsy_n_o, dten_n_o, dtei_n_o, done_o, irq5_o;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] buf_byte(input logic [13:0] a);
      return a[7:0] ^ {a[13:8], 2'b10};
   endfunction

   assign rd_data_i = buf_byte(rd_addr_o);

   cdbuf_dma u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
      .src_i(src_i), .dadr_i(dadr_i), .dbc_i(dbc_i), .hstat_i(hstat_i),
      .dteien_i(dteien_i), .ien5_i(ien5_i), .rd_addr_o(rd_addr_o),
      .rd_data_i(rd_data_i), .we_o(we_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .src_o(src_o), .dadr_o(dadr_o), .dbc_o(dbc_o),
      .chan_o(chan_o), .hstat_o(hstat_o), .dtbsy_n_o(dtbsy_n_o),
      .dten_n_o(dten_n_o), .dtei_n_o(dtei_n_o), .done_o(done_o), .irq5_o(irq5_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string addr_req(input logic [2:0] ch);
      if (ch == 3'd1) return "R4 sample RAM address";
      if (ch == 3'd2) return "R5 program RAM address";
      return "R6 work RAM address";
   endfunction

   task automatic run_vec(input vec_t v, input int inj_at);
      int base, lim, want, len, n, s0, exp_src, exp_dadr;
      n = int'(v.dbc) + 1;
      case (v.ch)
         3'd1: begin base = (int'(v.dadr) << 2) & 'hFFC;   lim = 'h1000;  end
         3'd2: begin base = int'(v.dadr) << 3;             lim = 'h80000; end
         3'd5: begin base = (int'(v.dadr) << 3) & 'h3FFFE; lim = 'h40000; end
         default: begin base = (int'(v.dadr) << 3) & 'h1FFFE; lim = 'h20000; end
      endcase
      want = (v.ch == 3'd1) ? n : (n & ~1);
      len  = (want > lim - base) ? (lim - base) : want;
      s0   = int'(v.src) & 'h3FFE;
      exp_src  = (int'(v.src) + want) & 'h3FFF;
      exp_dadr = (int'(v.dadr) + ((v.ch == 3'd1) ? (n >> 2) : (n >> 3))) & 'hFFFF;

      @(negedge clk);
      start_i = 1'b1; chan_i = v.ch; src_i = v.src; dadr_i = v.dadr;
      dbc_i = v.dbc; hstat_i = v.hs; dteien_i = v.ten; ien5_i = v.ien;
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 busy low during transfer", 32'(dtbsy_n_o), 32'd0);
      chk("R9 enable low during transfer", 32'(dten_n_o), 32'd0);
      chk("R10 pending armed", 32'(dtei_n_o), 32'd0);
      chk("R8 counter loaded", 32'(dbc_o), 32'(v.dbc));
      chk("R9 status loaded", 32'(hstat_o), 32'(v.hs));
      if (len == 0) chk("R6 zero length writes nothing", 32'(we_o), 32'd0);
      for (int k = 0; k < len; k++) begin
         if (k > 0) begin
            @(negedge clk);
            start_i = 1'b0;
         end
         if (k == inj_at) begin
            start_i = 1'b1; chan_i = 3'd2; src_i = 14'h0; dadr_i = 16'h0; dbc_i = 12'd1;
         end
         chk("R2 write strobe", 32'(we_o), 32'(1 << (int'(v.ch) - 1)));
         chk(addr_req(v.ch), 32'(wr_addr_o), 32'(base + k));
         chk("R3 source data", 32'(wr_data_o), 32'(buf_byte(14'((s0 + k) & 'h3FFF))));
      end
      @(negedge clk);
      start_i = 1'b0;
      chk("R11 done pulse", 32'(done_o), 32'd1);
      chk("R11 channel cleared", 32'(chan_o), 32'd0);
      chk("R8 counter reload", 32'(dbc_o), 32'hF000);
      chk("R7 source advance", 32'(src_o), 32'(exp_src));
      chk("R7 address advance", 32'(dadr_o), 32'(exp_dadr));
      chk("R9 flags idle", 32'({dtbsy_n_o, dten_n_o}), 32'd3);
      chk("R9 status final", 32'(hstat_o), 32'((int'(v.hs) & 7) | 'h80));
      chk("R10 irq request", 32'(irq5_o), 32'(v.ten & v.ien));
      chk("R10 pending cleared", 32'(dtei_n_o), 32'd1);
      chk("R2 no write after end", 32'(we_o), 32'd0);
      @(negedge clk);
      chk("R11 done single cycle", 32'(done_o), 32'd0);
      chk("R10 irq single cycle", 32'(irq5_o), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: all requirements, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(dtbsy_n_o), 32'd1);
      chk("R1 enable", 32'(dten_n_o), 32'd1);
      chk("R1 pending", 32'(dtei_n_o), 32'd1);
      chk("R1 done", 32'(done_o), 32'd0);
      chk("R1 irq", 32'(irq5_o), 32'd0);
      chk("R1 strobes", 32'(we_o), 32'd0);
      chk("R1 channel", 32'(chan_o), 32'd0);
      chk("R1 counter", 32'(dbc_o), 32'hF000);
      chk("R1 pointers", 32'({src_o, dadr_o}), 32'd0);
      chk("R1 status", 32'(hstat_o), 32'd0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], -1);

      // R12 start during a transfer is ignored
      run_vec(VECS[0], 3);

      // R12 invalid channel codes are ignored
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         start_i = 1'b1;
         chan_i = (c == 0) ? 3'd0 : ((c == 1) ? 3'd6 : 3'd7);
         src_i = 14'h1234; dadr_i = 16'h5555; dbc_i = 12'd7; hstat_i = 8'h3C;
         @(negedge clk);
         start_i = 1'b0;
         chk("R12 invalid code busy", 32'(dtbsy_n_o), 32'd1);
         chk("R12 invalid code strobes", 32'(we_o), 32'd0);
         chk("R12 invalid code channel", 32'(chan_o), 32'd0);
         chk("R12 invalid code counter", 32'(dbc_o), 32'hF000);
         chk("R12 invalid code source", 32'(src_o), 32'((int'(VECS[0].src) + 16) & 'h3FFF));
         chk("R12 invalid code status", 32'(hstat_o), 32'((int'(VECS[0].hs) & 7) | 'h80));
      end

      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule